// File: doc/BRIEF.md
# INCR Burst Page-Edge Splitter

The splitter sits between a master's request logic and an AXI address channel. It takes one incrementing access, described by a start address, a per-beat size code and a total byte count. It re-issues that access as a series of address-channel commands. No command runs across a 4 KB page, and none is longer than the 256-beat limit for incrementing bursts. The commands come out in ascending address order, and each one starts on the byte just after the end of the previous one.

Both sides use a valid/ready handshake. The request side is free only while the controller is in the `ST_IDLE` state. A request with a byte count of zero goes from `ST_IDLE` to `ST_FAULT`. It stays there for one cycle, raising the error flag, and then returns to `ST_IDLE` with no command emitted. Any other accepted request goes from `ST_IDLE` to `ST_ISSUE`. `ST_ISSUE` presents one piece at a time. It stays in `ST_ISSUE` after each handshake that leaves beats outstanding, and it returns to `ST_IDLE` on the handshake of the final piece.

Top module: `axi_page_splitter`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_valid` and `req_err` are low and `req_ready` is high.
- R2: The number of beats issued for a request equals the byte count divided by 2^`req_size`, rounded up. Every command carries `cmd_size` equal to the request's `req_size`.
- R3: For every command, the first byte (`cmd_addr`) and the last byte (`cmd_addr + (cmd_len+1)*2^cmd_size - 1`) have equal address bits [31:12].
- R4: Each piece's beat count is the smallest of three values: the beats still outstanding, the beats left before the next 4 KB edge, and 256. `cmd_len` is that count minus one.
- R5: The first command of a request has `cmd_addr` equal to the request's start address. Each later command starts at the previous command's address plus its byte length.
- R6: `cmd_last` is high on the final command of a request and low on every other command.
- R7: `req_ready` is low from the cycle after a request is accepted until the final command is handshaken. It is high again in the cycle that follows that handshake.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_addr`, `cmd_len`, `cmd_size` and `cmd_last` hold their values into the next cycle.
- R9: An accepted request with `req_bytes` equal to zero raises `req_err` for exactly one cycle, the cycle after acceptance. It produces no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken this cycle if valid |
| req_addr | input | ADDR_W | Start byte address, aligned to the beat size |
| req_size | input | 3 | Bytes per beat, as a power-of-two exponent |
| req_bytes | input | CNT_W | Total bytes to move |
| req_err | output | 1 | One-cycle pulse for a zero-byte request |
| cmd_valid | output | 1 | Command piece offered |
| cmd_ready | input | 1 | Downstream takes the piece |
| cmd_addr | output | ADDR_W | Piece start address |
| cmd_len | output | $clog2(MAX_BEATS) | Piece beats minus one |
| cmd_size | output | 3 | Piece beat size code |
| cmd_last | output | 1 | Final piece of the request |

## Verification
The assertions assume the master aligns each start address to its beat size. They also assume it holds the request fields steady while `req_valid` waits for `req_ready`. The page-crossing and contiguity properties are only meaningful under those two conditions. The stimulus keeps to them: every start address it uses is a multiple of 2^size, and it changes request fields only at acceptance. Byte counts that are not a multiple of the beat size are still exercised, because rounding up is part of the defined behaviour.

// File: rtl/axsplit_pkg.sv
package axsplit_pkg;

    // Controller states of the splitter.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FAULT = 2'd2
    } split_state_e;

    // Width of the beat-size exponent.
    localparam int SIZE_W = 3;

endpackage

// File: rtl/axsplit_beats.sv
// Converts a byte count into a beat count, rounding up to whole beats.
module axsplit_beats
    import axsplit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0]  bytes_in,
    input  logic [SIZE_W-1:0] size_in,
    output logic [CNT_W-1:0]  beats_out
);

    localparam int WW = CNT_W + 1;

    logic [WW-1:0] round_up;
    logic [WW-1:0] shifted;

    always_comb begin
        round_up = {1'b0, bytes_in} + (WW'(1) << size_in) - WW'(1);
        shifted  = round_up >> size_in;
    end

    assign beats_out = CNT_W'(shifted);

endmodule

// File: rtl/axsplit_piece.sv
// Sizes the next piece: the smallest of the outstanding beats, the beats left
// before the page edge, and the burst cap.
module axsplit_piece
    import axsplit_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int CNT_W     = 16,
    parameter int MAX_BEATS = 256
) (
    input  logic [PAGE_BITS-1:0]           offs_in,
    input  logic [SIZE_W-1:0]              size_in,
    input  logic [CNT_W-1:0]               rem_in,
    output logic [$clog2(MAX_BEATS):0]     piece_beats,
    output logic                           piece_last
);

    localparam int CAP_W = $clog2(MAX_BEATS) + 1;
    localparam int MW    = (CNT_W > PAGE_BITS) ? CNT_W + 1 : PAGE_BITS + 1;

    logic [MW-1:0] room_bytes;
    logic [MW-1:0] room_beats;
    logic [MW-1:0] fit;
    logic [MW-1:0] capped;

    always_comb begin
        room_bytes = (MW'(1) << PAGE_BITS) - MW'(offs_in);
        room_beats = room_bytes >> size_in;
        fit        = (MW'(rem_in) < room_beats) ? MW'(rem_in) : room_beats;
    end

    // The cap comparator is needed only when a page can hold more beats than the cap.
    if (MAX_BEATS >= (1 << PAGE_BITS)) begin : g_nocap
        assign capped = fit;
    end else begin : g_cap
        assign capped = (fit > MW'(MAX_BEATS)) ? MW'(MAX_BEATS) : fit;
    end

    assign piece_beats = CAP_W'(capped);
    assign piece_last  = (MW'(rem_in) == capped);

endmodule

// File: rtl/axi_page_splitter.sv
module axi_page_splitter
    import axsplit_pkg::*;
#(
    parameter  int ADDR_W    = 32,
    parameter  int CNT_W     = 16,
    parameter  int PAGE_BITS = 12,
    parameter  int MAX_BEATS = 256,
    localparam int LEN_W     = $clog2(MAX_BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [CNT_W-1:0]  req_bytes,
    output logic              req_err,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic [SIZE_W-1:0] cmd_size,
    output logic              cmd_last
);

    localparam int CAP_W = LEN_W + 1;

    split_state_e      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size_q;
    logic [CNT_W-1:0]  rem_q;

    logic [CNT_W-1:0]  req_beats;
    logic [CAP_W-1:0]  piece;
    logic              piece_last;
    logic              take_req;
    logic              take_cmd;

    axsplit_beats #(.CNT_W(CNT_W)) u_beats (
        .bytes_in  (req_bytes),
        .size_in   (req_size),
        .beats_out (req_beats)
    );

    axsplit_piece #(
        .PAGE_BITS (PAGE_BITS),
        .CNT_W     (CNT_W),
        .MAX_BEATS (MAX_BEATS)
    ) u_piece (
        .offs_in     (addr_q[PAGE_BITS-1:0]),
        .size_in     (size_q),
        .rem_in      (rem_q),
        .piece_beats (piece),
        .piece_last  (piece_last)
    );

    assign take_req = req_valid && req_ready;
    assign take_cmd = cmd_valid && cmd_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = (req_bytes == '0) ? ST_FAULT : ST_ISSUE;
            end
            ST_ISSUE: begin
                if (cmd_ready && piece_last) state_d = ST_IDLE;
            end
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Working registers: next address, beat size and outstanding beats
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            size_q <= '0;
            rem_q  <= '0;
        end else if (take_req) begin
            addr_q <= req_addr;
            size_q <= req_size;
            rem_q  <= req_beats;
        end else if (take_cmd) begin
            addr_q <= addr_q + (ADDR_W'(piece) << size_q);
            rem_q  <= rem_q - CNT_W'(piece);
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        req_err   = 1'b0;
        cmd_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: cmd_valid = 1'b1;
            ST_FAULT: req_err   = 1'b1;
            default:  ;
        endcase
        cmd_addr = addr_q;
        cmd_len  = LEN_W'(piece - CAP_W'(1));
        cmd_size = size_q;
        cmd_last = piece_last;
    end

    // ---------------------------------------------------------------- checks
    logic [ADDR_W-1:0] chk_end;
    assign chk_end = cmd_addr + ((ADDR_W'(cmd_len) + ADDR_W'(1)) << cmd_size) - ADDR_W'(1);

    p_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_addr[ADDR_W-1:PAGE_BITS] == chk_end[ADDR_W-1:PAGE_BITS]));

    p_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_bytes != '0) |=> (cmd_valid && cmd_addr == $past(req_addr)));

    p_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_last) |=>
            (cmd_valid && cmd_addr == $past(cmd_addr) +
                ((ADDR_W'($past(cmd_len)) + ADDR_W'(1)) << $past(cmd_size))));

    p_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_last) |=> (cmd_size == $past(cmd_size)));

    p_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_last) |=> req_ready);

    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_bytes != '0) |=> !req_ready);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) &&
             $stable(cmd_size) && $stable(cmd_last)));

    p_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_bytes == '0) |=> (req_err && !cmd_valid));

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !req_err);

endmodule

// File: tb/sim_axi_page_splitter.sv
`timescale 1ns/100ps
module sim_axi_page_splitter;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0]        req_size = '0;
    logic [CNT_W-1:0]  req_bytes = '0;
    logic              req_err;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_len;
    logic [2:0]        cmd_size;
    logic              cmd_last;

    axi_page_splitter u0 (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_size, .req_bytes,
        .req_err, .cmd_valid, .cmd_ready, .cmd_addr, .cmd_len, .cmd_size, .cmd_last
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        logic [31:0] addr;
        logic [7:0]  len;
        logic [2:0]  size;
        logic        last;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    bit   busy_mode = 1;   // 1: random backpressure

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Expected pieces derived from the requirements (R2, R4, R5, R6)
    task automatic push_expect(input logic [31:0] a0, input logic [2:0] sz, input int unsigned nbytes);
        int unsigned left = (nbytes + (1 << sz) - 1) >> sz;
        logic [31:0] a = a0;
        while (left > 0) begin
            int unsigned room = (4096 - (a & 32'hFFF)) >> sz;
            int unsigned n = left;
            exp_t e;
            if (room < n) n = room;
            if (256 < n) n = 256;
            e.addr = a; e.len = 8'(n - 1); e.size = sz; e.last = (n == left);
            exp_q.push_back(e);
            a = a + (n << sz);
            left = left - n;
        end
    endtask

    // Driver
    task automatic send(input logic [31:0] a, input logic [2:0] sz, input int unsigned nbytes);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_bytes = CNT_W'(nbytes);
        forever begin
            #0.5;
            if (req_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        push_expect(a, sz, nbytes);
        @(negedge clk);
        req_valid = 1'b0;
        if (nbytes == 0) begin
            #0.5;
            check(req_err === 1'b1, "R9 err pulse", req_err, 1);
            check(cmd_valid === 1'b0, "R9 no command", cmd_valid, 0);
            @(negedge clk); #0.5;
            check(req_err === 1'b0, "R9 err one cycle", req_err, 0);
            check(req_ready === 1'b1, "R7 ready after fault", req_ready, 1);
        end
    endtask

    // Monitor / scoreboard
    bit          held = 0;
    logic [31:0] h_addr;
    logic [7:0]  h_len;
    logic [2:0]  h_size;
    logic        h_last;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmd_ready = busy_mode ? ($urandom_range(0, 3) != 0) : 1'b1;
            #0.5;
            if (held) begin
                check(cmd_valid === 1'b1 && cmd_addr == h_addr && cmd_len == h_len &&
                      cmd_size == h_size && cmd_last == h_last,
                      "R8 hold under backpressure", cmd_addr, h_addr);
            end
            if (exp_q.size() > 0 && req_ready)
                check(0, "R7 ready while pieces pending", req_ready, 0);
            held = cmd_valid && !cmd_ready;
            h_addr = cmd_addr; h_len = cmd_len; h_size = cmd_size; h_last = cmd_last;
            if (cmd_valid && cmd_ready) begin
                logic [31:0] lastb;
                lastb = cmd_addr + ((32'(cmd_len) + 1) << cmd_size) - 1;
                check(cmd_addr[31:12] == lastb[31:12], "R3 page crossing", lastb, cmd_addr);
                if (exp_q.size() == 0) begin
                    check(0, "R9 unexpected command", cmd_addr, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cmd_addr == e.addr, "R5 address", cmd_addr, e.addr);
                    check(cmd_len == e.len, "R4 length", cmd_len, e.len);
                    check(cmd_size == e.size, "R2 size", cmd_size, e.size);
                    check(cmd_last == e.last, "R6 last flag", cmd_last, e.last);
                end
            end
        end
    end

    task automatic drain;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk); #0.5;
        check(req_ready === 1'b1, "R7 ready after final piece", req_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cmd_valid === 1'b0 && req_err === 1'b0 && req_ready === 1'b1,
              "R1 reset state", {cmd_valid, req_err, req_ready}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk); #0.5;
        check(cmd_valid === 1'b0 && req_ready === 1'b1, "R1 after reset",
              {cmd_valid, req_ready}, 2'b01);

        send(32'h0000_1FF0, 3'd2, 32);    // R3 two pieces across 0x2000
        drain();
        send(32'h0000_1FFC, 3'd2, 8);     // R3 short burst still split
        drain();
        send(32'h0000_0100, 3'd2, 10);    // R2 rounding up to 3 beats
        drain();
        send(32'h0000_0F80, 3'd7, 256);   // R4 one beat to page edge
        drain();
        send(32'h0000_0000, 3'd0, 4096);  // R4 cap at 256 beats, 16 pieces
        drain();
        send(32'h0000_3000, 3'd3, 8192);  // R4 cap within large beats
        drain();
        send(32'h0000_5000, 3'd2, 0);     // R9 zero bytes
        drain();
        // back-to-back requests while busy (R7)
        send(32'h0000_7FE0, 3'd3, 100);
        send(32'h0001_0004, 3'd2, 4);
        send(32'h0000_8000, 3'd1, 0);
        send(32'h0002_0FF8, 3'd3, 40);
        drain();
        busy_mode = 0;
        for (int i = 0; i < 20; i++) begin
            logic [2:0] sz = 3'($urandom_range(0, 5));
            logic [31:0] a = ($urandom_range(0, 32'hFFFF) >> sz) << sz;
            send(a, sz, $urandom_range(1, 3000));
            if (i == 9) busy_mode = 1;
        end
        drain();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule